// File: doc/BRIEF.md
# Dual-Core Mailbox with Hardware Mutex

This block lets two processor cores pass signals to each other through a pair of 32-bit words held in registers. Each core has its own word. Either core can reach either word through its own register port, using the address to pick the entry. A word can be loaded whole. It can also be changed atomically through a set alias, which ORs the written bits in, or through a clear alias, which removes the written bits. Whenever a word is nonzero, the level interrupt to the core that owns it stays high. The receiving core clears the bits it has handled, and the interrupt drops once the word reaches zero.

A single shared mutex bit arbitrates access to common resources. A read of the mutex register returns 1 to the caller that finds it free and takes it in the same access. Any other read returns 0. Writing a 1 frees it again. Each core has its own port, and each port is single-cycle:

- Read data is valid in the same cycle as the request.
- State changes at the next rising clock edge.
- When both cores reach the same state in one cycle, fixed ordering rules decide the result.

Top module: `dual_mailbox`

## Requirements
- R1: After reset, both words read as 0, both interrupts are low, and the first mutex read returns 1.
- R2: A write at byte offset 0x10*n (n = 0 or 1) loads entry n with the full data word. A read at that offset returns the stored word. Both ports reach both entries.
- R3: A write at offset 0x10*n+4 ORs the data into entry n. Writing 0 there leaves the word unchanged.
- R4: A write at offset 0x10*n+8 clears each bit of entry n where the data is 1. Writing 0 there leaves the word unchanged.
- R5: A read of a set or clear alias, or of any unmapped offset, returns 0. Port read data is 0 when the port is not reading. Writes to unmapped offsets change nothing.
- R6: `core_irq[n]` is high exactly while entry n is nonzero, starting from the cycle after the write that changes the word.
- R7: A read at offset 0xF8 while the mutex is free returns 1 in bit 0 and 0 in all other bits, and it takes the mutex.
- R8: A read at offset 0xF8 while the mutex is taken returns 0 and leaves it taken.
- R9: A write at 0xF8 with data bit 0 set frees the mutex. A write with bit 0 clear has no effect.
- R10: When both ports read a free mutex in the same cycle, port 0 receives 1 and port 1 receives 0.
- R11: When both ports write the same entry in the same cycle, port 0's operation is applied first and port 1's operation is then applied to that result.
- R12: When one port frees a taken mutex while the other port reads it in the same cycle, the read returns 0 and the mutex is free afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| c0_sel | input | 1 | Port 0 access strobe |
| c0_wr | input | 1 | Port 0 write (1) or read (0) |
| c0_addr | input | AW | Port 0 byte offset |
| c0_wdata | input | DW | Port 0 write data |
| c0_rdata | output | DW | Port 0 read data, same cycle |
| c1_sel | input | 1 | Port 1 access strobe |
| c1_wr | input | 1 | Port 1 write (1) or read (0) |
| c1_addr | input | AW | Port 1 byte offset |
| c1_wdata | input | DW | Port 1 write data |
| c1_rdata | output | DW | Port 1 read data, same cycle |
| core_irq | output | 2 | Level interrupt per entry, to its owning core |

## Verification
The two ports can collide in one cycle in two ways: both touch the same mailbox word, or both touch the mutex. Directed cycles drive both ports together for each of these cases:
- A load paired with a set, and a set paired with a clear, on one word.
- A dual acquire of a free mutex.
- A release on one port while the other port reads.

A random phase then mixes both ports across every offset, so collisions also occur at random. A behavioural model applies port 0 before port 1 and judges read data and interrupts on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NUM_CORES    = 2;
  localparam int ENTRY_STRIDE = 16;
  localparam int OFS_LOAD     = 0;
  localparam int OFS_SET      = 4;
  localparam int OFS_CLR      = 8;
  localparam int OFS_MUTEX    = 248;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_LOAD,
    OP_SET,
    OP_CLR
  } word_op_e;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int IW = 1
) (
  input  logic                          sel,
  input  logic                          wr,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  input  logic [NUM_CORES-1:0][DW-1:0]  words,
  input  logic                          grant,
  output word_op_e                      op,
  output logic [IW-1:0]                 idx,
  output logic                          mtx_rd,
  output logic                          mtx_rel,
  output logic [DW-1:0]                 rdata
);
  logic          load_hit;
  logic [IW-1:0] load_idx;
  logic          mtx_hit;

  // Address decode for word operations
  always_comb begin
    op       = OP_NONE;
    idx      = '0;
    load_hit = 1'b0;
    load_idx = '0;
    for (int e = 0; e < NUM_CORES; e++) begin
      if (addr == AW'(e * ENTRY_STRIDE + OFS_LOAD)) begin
        load_hit = 1'b1;
        load_idx = IW'(e);
      end
      if (sel && wr) begin
        if (addr == AW'(e * ENTRY_STRIDE + OFS_LOAD)) begin
          op  = OP_LOAD;
          idx = IW'(e);
        end else if (addr == AW'(e * ENTRY_STRIDE + OFS_SET)) begin
          op  = OP_SET;
          idx = IW'(e);
        end else if (addr == AW'(e * ENTRY_STRIDE + OFS_CLR)) begin
          op  = OP_CLR;
          idx = IW'(e);
        end
      end
    end
  end

  assign mtx_hit = (addr == AW'(OFS_MUTEX));
  assign mtx_rd  = sel && !wr && mtx_hit;
  assign mtx_rel = sel && wr && mtx_hit && wdata[0];

  // Read data: aliases and holes return zero
  always_comb begin
    rdata = '0;
    if (sel && !wr) begin
      if (mtx_hit)       rdata = DW'(grant);
      else if (load_hit) rdata = words[load_idx];
    end
  end
endmodule

// File: rtl/mbx_word.sv
module mbx_word
  import mbx_pkg::*;
#(
  parameter int DW  = 32,
  parameter int IW  = 1,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  word_op_e             op    [NUM_CORES],
  input  logic [IW-1:0]        idx   [NUM_CORES],
  input  logic [DW-1:0]        data  [NUM_CORES],
  output logic [DW-1:0]        word_q
);
  logic [DW-1:0] word_d;
  logic          word_en;

  // Ports applied in ascending order: lower port first
  always_comb begin
    word_d  = word_q;
    word_en = 1'b0;
    for (int p = 0; p < NUM_CORES; p++) begin
      if (idx[p] == IW'(IDX)) begin
        case (op[p])
          OP_LOAD: begin word_d = data[p];           word_en = 1'b1; end
          OP_SET:  begin word_d = word_d | data[p];  word_en = 1'b1; end
          OP_CLR:  begin word_d = word_d & ~data[p]; word_en = 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end
endmodule

// File: rtl/mbx_mutex.sv
module mbx_mutex #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] rd_req,
  input  logic [NP-1:0] rel_req,
  output logic [NP-1:0] grant
);
  logic free_q;
  logic free_d;
  logic free_en;
  logic claimed;

  // Fixed priority: lowest port index wins a free mutex
  always_comb begin
    claimed = 1'b0;
    for (int p = 0; p < NP; p++) begin
      grant[p] = free_q && rd_req[p] && !claimed;
      claimed  = claimed | rd_req[p];
    end
  end

  // An acquire outranks a release in the same cycle
  always_comb begin
    free_en = 1'b0;
    free_d  = free_q;
    if (|grant) begin
      free_en = 1'b1;
      free_d  = 1'b0;
    end else if (|rel_req) begin
      free_en = 1'b1;
      free_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       free_q <= 1'b1;
    else if (free_en) free_q <= free_d;
  end
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
  import mbx_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 c0_sel,
  input  logic                 c0_wr,
  input  logic [AW-1:0]        c0_addr,
  input  logic [DW-1:0]        c0_wdata,
  output logic [DW-1:0]        c0_rdata,
  input  logic                 c1_sel,
  input  logic                 c1_wr,
  input  logic [AW-1:0]        c1_addr,
  input  logic [DW-1:0]        c1_wdata,
  output logic [DW-1:0]        c1_rdata,
  output logic [NUM_CORES-1:0] core_irq
);
  localparam int IW = $clog2(NUM_CORES);

  logic                         rst_q_n;
  logic [NUM_CORES-1:0]         p_sel;
  logic [NUM_CORES-1:0]         p_wr;
  logic [AW-1:0]                p_addr  [NUM_CORES];
  logic [DW-1:0]                p_wdata [NUM_CORES];
  logic [DW-1:0]                p_rdata [NUM_CORES];
  word_op_e                     p_op    [NUM_CORES];
  logic [IW-1:0]                p_idx   [NUM_CORES];
  logic [NUM_CORES-1:0]         p_mtx_rd;
  logic [NUM_CORES-1:0]         p_mtx_rel;
  logic [NUM_CORES-1:0]         p_grant;
  logic [NUM_CORES-1:0][DW-1:0] word_q;

  mbx_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign p_sel      = {c1_sel, c0_sel};
  assign p_wr       = {c1_wr, c0_wr};
  assign p_addr[0]  = c0_addr;
  assign p_addr[1]  = c1_addr;
  assign p_wdata[0] = c0_wdata;
  assign p_wdata[1] = c1_wdata;
  assign c0_rdata   = p_rdata[0];
  assign c1_rdata   = p_rdata[1];

  for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
    mbx_port_dec #(.AW(AW), .DW(DW), .IW(IW)) u_dec (
      .sel     (p_sel[p]),
      .wr      (p_wr[p]),
      .addr    (p_addr[p]),
      .wdata   (p_wdata[p]),
      .words   (word_q),
      .grant   (p_grant[p]),
      .op      (p_op[p]),
      .idx     (p_idx[p]),
      .mtx_rd  (p_mtx_rd[p]),
      .mtx_rel (p_mtx_rel[p]),
      .rdata   (p_rdata[p])
    );
  end

  for (genvar e = 0; e < NUM_CORES; e++) begin : g_entry
    mbx_word #(.DW(DW), .IW(IW), .IDX(e)) u_word (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .op     (p_op),
      .idx    (p_idx),
      .data   (p_wdata),
      .word_q (word_q[e])
    );
    assign core_irq[e] = |word_q[e];
  end

  mbx_mutex #(.NP(NUM_CORES)) u_mtx (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .rd_req  (p_mtx_rd),
    .rel_req (p_mtx_rel),
    .grant   (p_grant)
  );
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                c0_sel,
  input logic                c0_wr,
  input logic [AW-1:0]       c0_addr,
  input logic [DW-1:0]       c0_wdata,
  input logic [DW-1:0]       c0_rdata,
  input logic                c1_sel,
  input logic                c1_wr,
  input logic [AW-1:0]       c1_addr,
  input logic [DW-1:0]       c1_wdata,
  input logic [DW-1:0]       c1_rdata,
  input logic [1:0]          core_irq,
  input logic [1:0][DW-1:0]  word_q
);
  localparam logic [AW-1:0] A_MTX  = AW'(248);
  localparam logic [AW-1:0] A_SET0 = AW'(4);
  localparam logic [AW-1:0] A_CLR0 = AW'(8);
  localparam logic [AW-1:0] A_VAL1 = AW'(16);

  logic c0_mrd, c1_mrd, c0_win, c1_win, any_rel;
  assign c0_mrd  = c0_sel && !c0_wr && c0_addr == A_MTX;
  assign c1_mrd  = c1_sel && !c1_wr && c1_addr == A_MTX;
  assign c0_win  = c0_mrd && c0_rdata[0];
  assign c1_win  = c1_mrd && c1_rdata[0];
  assign any_rel = (c0_sel && c0_wr && c0_addr == A_MTX && c0_wdata[0]) ||
                   (c1_sel && c1_wr && c1_addr == A_MTX && c1_wdata[0]);

  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (c0_sel && c0_wr && c0_addr == A_SET0 && !c1_sel) |=> word_q[0] == ($past(word_q[0]) | $past(c0_wdata))); // R3
  AST_CLR_MASKS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (c0_sel && c0_wr && c0_addr == A_CLR0 && !c1_sel) |=> word_q[0] == ($past(word_q[0]) & ~$past(c0_wdata))); // R4
  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_q_n)
    (c0_sel && c0_wr && c0_addr == A_VAL1 && c0_wdata != '0 && !c1_sel) |=> core_irq[1]); // R6
  AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (c0_sel && !c0_wr && c0_addr == A_SET0) |-> c0_rdata == '0); // R5
  AST_MUTEX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    c0_mrd |-> c0_rdata[DW-1:1] == '0); // R7
  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(c0_win && c1_win)); // R10
  AST_HELD_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((c0_win || c1_win) && !any_rel) |=> !(c0_win || c1_win)); // R8
endmodule

bind dual_mailbox mbx_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .c0_sel   (c0_sel),
  .c0_wr    (c0_wr),
  .c0_addr  (c0_addr),
  .c0_wdata (c0_wdata),
  .c0_rdata (c0_rdata),
  .c1_sel   (c1_sel),
  .c1_wr    (c1_wr),
  .c1_addr  (c1_addr),
  .c1_wdata (c1_wdata),
  .c1_rdata (c1_rdata),
  .core_irq (core_irq),
  .word_q   (word_q)
);

// File: tb/sim_dual_mailbox.sv
`timescale 1ns/1ps
module sim_dual_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        c0_sel = 0, c0_wr = 0, c1_sel = 0, c1_wr = 0;
  logic [7:0]  c0_addr = 0, c1_addr = 0;
  logic [31:0] c0_wdata = 0, c1_wdata = 0;
  logic [31:0] c0_rdata, c1_rdata;
  logic [1:0]  core_irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference state
  logic [31:0] m_word [2];
  bit          m_free;

  always #2.5 clk = ~clk;

  dual_mailbox u0 (
    .clk(clk), .rst_n(rst_n),
    .c0_sel(c0_sel), .c0_wr(c0_wr), .c0_addr(c0_addr), .c0_wdata(c0_wdata), .c0_rdata(c0_rdata),
    .c1_sel(c1_sel), .c1_wr(c1_wr), .c1_addr(c1_addr), .c1_wdata(c1_wdata), .c1_rdata(c1_rdata),
    .core_irq(core_irq)
  );

  function automatic bit is_mrd(bit s, bit w, logic [7:0] a);
    return s && !w && a == 8'hF8;
  endfunction

  function automatic logic [31:0] mdl_read(bit s, bit w, logic [7:0] a, bit blocked);
    if (!s || w) return 32'h0;
    case (a)
      8'h00:   return m_word[0];
      8'h10:   return m_word[1];
      8'hF8:   return {31'h0, m_free && !blocked};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mdl_apply(logic [31:0] w, int e, bit s, bit wr, logic [7:0] a, logic [31:0] d);
    if (!(s && wr)) return w;
    if (a == 8'(e*16))     return d;
    if (a == 8'(e*16 + 4)) return w | d;
    if (a == 8'(e*16 + 8)) return w & ~d;
    return w;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(string req,
                     bit s0, bit w0, logic [7:0] a0, logic [31:0] d0,
                     bit s1, bit w1, logic [7:0] a1, logic [31:0] d1);
    logic [31:0] e0, e1, n0, n1;
    bit g, rel;
    @(negedge clk);
    c0_sel = s0; c0_wr = w0; c0_addr = a0; c0_wdata = d0;
    c1_sel = s1; c1_wr = w1; c1_addr = a1; c1_wdata = d1;
    #1;
    e0 = mdl_read(s0, w0, a0, 1'b0);
    e1 = mdl_read(s1, w1, a1, is_mrd(s0, w0, a0));
    vectors++;
    chk(req, "c0_rdata", c0_rdata, e0);
    chk(req, "c1_rdata", c1_rdata, e1);
    chk(req, "core_irq", {30'h0, core_irq}, {30'h0, m_word[1] != 0, m_word[0] != 0});
    for (int e = 0; e < 2; e++) begin
      n0 = mdl_apply(m_word[e], e, s0, w0, a0, d0);
      n1 = mdl_apply(n0, e, s1, w1, a1, d1);
      if (e == 0) e0 = n1; else e1 = n1;
    end
    g   = m_free && (is_mrd(s0, w0, a0) || is_mrd(s1, w1, a1));
    rel = (s0 && w0 && a0 == 8'hF8 && d0[0]) || (s1 && w1 && a1 == 8'hF8 && d1[0]);
    @(posedge clk);
    m_word[0] = e0;
    m_word[1] = e1;
    if (g) m_free = 0; else if (rel) m_free = 1;
  endtask

  task automatic idle(string req);
    cyc(req, 0, 0, 8'h00, 0, 0, 0, 8'h00, 0);
  endtask
  task automatic w0op(string req, logic [7:0] a, logic [31:0] d);
    cyc(req, 1, 1, a, d, 0, 0, 8'h00, 0);
  endtask
  task automatic w1op(string req, logic [7:0] a, logic [31:0] d);
    cyc(req, 0, 0, 8'h00, 0, 1, 1, a, d);
  endtask
  task automatic r0op(string req, logic [7:0] a);
    cyc(req, 1, 0, a, 0, 0, 0, 8'h00, 0);
  endtask
  task automatic r1op(string req, logic [7:0] a);
    cyc(req, 0, 0, 8'h00, 0, 1, 0, a, 0);
  endtask

  function automatic logic [7:0] pick_addr(int k);
    case (k)
      0: return 8'h00; 1: return 8'h04; 2: return 8'h08; 3: return 8'h10;
      4: return 8'h14; 5: return 8'h18; 6: return 8'hF8; default: return 8'h0C;
    endcase
  endfunction

  initial begin
    #500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_word[0] = 0; m_word[1] = 0; m_free = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    idle("R1");
    cyc("R1", 1, 0, 8'h00, 0, 1, 0, 8'h10, 0);
    r1op("R1", 8'hF8);
    w1op("R9", 8'hF8, 32'h1);

    // R2 full loads, cross-port access
    w0op("R2", 8'h00, 32'hDEADBEEF);
    w1op("R2", 8'h10, 32'h12345678);
    cyc("R2", 1, 0, 8'h10, 0, 1, 0, 8'h00, 0);
    w1op("R2", 8'h00, 32'hA5A50001);
    r0op("R2", 8'h00);

    // R6 interrupt level
    w0op("R6", 8'h00, 32'h0);
    idle("R6");
    w1op("R6", 8'h10, 32'h0);
    idle("R6");

    // R3 set alias
    w0op("R3", 8'h14, 32'h0);
    w0op("R3", 8'h14, 32'h00F00000);
    w1op("R3", 8'h14, 32'h00000003);
    w0op("R3", 8'h14, 32'h0);
    r1op("R3", 8'h10);

    // R4 clear alias
    w1op("R4", 8'h18, 32'h0);
    w1op("R4", 8'h18, 32'h00100001);
    r0op("R4", 8'h10);
    w0op("R4", 8'h18, 32'hFFFFFFFF);
    idle("R4");

    // R5 aliases, holes, unmapped writes
    w0op("R5", 8'h00, 32'h0000CAFE);
    r0op("R5", 8'h04);
    r1op("R5", 8'h08);
    r0op("R5", 8'h14);
    r1op("R5", 8'h18);
    r0op("R5", 8'h0C);
    r1op("R5", 8'h40);
    w0op("R5", 8'h0C, 32'hFFFFFFFF);
    w1op("R5", 8'h40, 32'hFFFFFFFF);
    cyc("R5", 1, 0, 8'h00, 0, 1, 0, 8'h10, 0);

    // R7 / R8 / R9 mutex sequence
    r0op("R7", 8'hF8);
    r1op("R8", 8'hF8);
    r0op("R8", 8'hF8);
    w1op("R9", 8'hF8, 32'hFFFFFFFE);
    r1op("R9", 8'hF8);
    w1op("R9", 8'hF8, 32'h1);
    r1op("R7", 8'hF8);

    // R12 release and read together while taken
    cyc("R12", 1, 0, 8'hF8, 0, 1, 1, 8'hF8, 32'h1);
    r0op("R12", 8'hF8);
    w0op("R12", 8'hF8, 32'h1);

    // R10 simultaneous acquire
    cyc("R10", 1, 0, 8'hF8, 0, 1, 0, 8'hF8, 0);
    cyc("R10", 1, 0, 8'hF8, 0, 1, 0, 8'hF8, 0);
    w0op("R10", 8'hF8, 32'h1);

    // R11 same-entry collisions
    cyc("R11", 1, 1, 8'h00, 32'h000000FF, 1, 1, 8'h04, 32'h00000100);
    cyc("R11", 1, 1, 8'h04, 32'h0000F000, 1, 1, 8'h08, 32'h0000FFFF);
    r0op("R11", 8'h00);
    cyc("R11", 1, 1, 8'h08, 32'hFFFFFFFF, 1, 1, 8'h00, 32'h00000042);
    cyc("R11", 1, 1, 8'h10, 32'h0F0F0F0F, 1, 1, 8'h10, 32'h00000000);
    cyc("R11", 1, 0, 8'h00, 0, 1, 0, 8'h10, 0);

    // Mixed random traffic on both ports
    for (int i = 0; i < 400; i++) begin
      cyc("R11", 1'($urandom), 1'($urandom), pick_addr($urandom % 8), $urandom,
                 1'($urandom), 1'($urandom), pick_addr($urandom % 8), $urandom);
    end

    idle("R6");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule